// File: doc/BRIEF.md
# Load Multiple Register Sequencer

This block carries out a multi-register load. A caller gives it a first register number, a last register number and a 24-bit byte address. The block then fills general registers one at a time, in ascending number order, with full 32-bit words read from consecutive storage. When the last register number is below the first one, the walk passes register 15 and continues from register 0. Storage is byte-addressed, so the read address moves on by four for every register. The address wraps modulo 2^24.

The block has three interfaces. A start pulse opens an operation, and a one-cycle done pulse closes it. The storage read port has one request and one valid, and only one read is in flight at any time. The register-file write port is fully registered. The storage port returns four byte lanes: lane 0 is the byte at the requested address. The block packs these lanes big-endian, so the byte at the lowest address ends up in the most significant byte of the register.

Top module: `ldm_sequencer`

## Requirements
- R1: `start_i` is taken only while `busy_o` is low. `busy_o` rises in the cycle after an accepted start and stays high up to and including the `done_o` cycle.
- R2: The first read request of an operation is raised in the cycle after the accepted start, at `base_addr_i`. The first register write of the operation targets `first_reg_i`.
- R3: Registers are written in the order first, first+1, … modulo 16, ending with `last_reg_i` included. The operation writes ((last − first) mod 16) + 1 registers: one register when the two numbers are equal, and all sixteen when last = first − 1.
- R4: Read number k (counted from 0) of an operation uses address `base_addr_i` + 4·k modulo 2^24.
- R5: `mem_req_o` is high for exactly one cycle per read. No new request is raised until the word for the previous request has been taken.
- R6: A word is taken in a cycle where the block is waiting for a read and `mem_valid_i` is high. The matching register write (`rf_we_o` high) appears in the next cycle. A `mem_valid_i` at any other time has no effect.
- R7: `mem_rdata_i[7:0]` holds the byte at the read address and `mem_rdata_i[8k+7:8k]` holds the byte at address + k. The written word has the lane-0 byte in bits 31:24 and the lane-3 byte in bits 7:0.
- R8: `done_o` is high for exactly one cycle, the cycle after the final register write. `busy_o` is low in the cycle after that.
- R9: A start pulse that arrives while busy, including in the `done_o` cycle, is dropped. It causes no later read request, and the operation in flight keeps its latched fields.
- R10: While `rst_n` is low at a clock edge, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are all low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| first_reg_i | input | 4 | First register to load |
| last_reg_i | input | 4 | Last register to load (inclusive) |
| base_addr_i | input | 24 | Byte address of the first word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Read request, one cycle per word |
| mem_addr_o | output | 24 | Byte address of the requested word |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Four byte lanes, lane 0 at the lowest address |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register number being written |
| rf_wdata_o | output | 32 | Big-endian word being written |

## Verification
Two pairs of events can land in the same cycle. First, the registered write of one register coincides with the read request for the next register. Second, a new start pulse can coincide with the done pulse. The bench hits the first case every time the memory answers after one cycle. It hits the second by driving start in exactly the cycle its model marks as done. Both are judged by a queue-based model checked every clock: the write must carry the register and packed word of the finished read while the new request shows the next address, and the overlapping start must produce no request and no busy in the idle cycles that follow.

// File: rtl/ldm_pkg.sv
// Package: types shared by the load-multiple sequencer modules.
package ldm_pkg;

    // Sequencer phases; TAIL is the cycle holding the final registered write.
    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_WAIT,
        S_TAIL,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/ldm_ctrl.sv
// ldm_ctrl: phase controller of the load-multiple sequencer.
// Raises one read request per register, waits for the data word, and
// decides between the next register and the closing tail/done cycles.
// Assumes last_hit_i is valid whenever the controller is in S_WAIT.
module ldm_ctrl
    import ldm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    input  logic last_hit_i,
    output logic load_o,
    output logic req_o,
    output logic take_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (start_i) state_d = S_REQ;
            S_REQ:   state_d = S_WAIT;
            S_WAIT:  if (valid_i) state_d = last_hit_i ? S_TAIL : S_REQ;
            S_TAIL:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Decoded controls for the cursor, the write port and the handshake.
    always_comb begin
        load_o = (state_q == S_IDLE) && start_i;
        req_o  = (state_q == S_REQ);
        take_o = (state_q == S_WAIT) && valid_i;
        step_o = take_o && !last_hit_i;
        busy_o = (state_q != S_IDLE);
        done_o = (state_q == S_DONE);
    end

    // R5: a request never lasts two cycles.
    p_single_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R8: done is a single pulse and is followed by idle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R9: a start seen on the done cycle does not restart the sequencer.
    p_start_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !busy_o);

    // R1: busy is held through every phase up to done.
    p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/ldm_cursor.sv
// ldm_cursor: register-number and byte-address cursor.
// Latches the first/last register and base address on load, then steps
// the register number modulo 2^REG_W and the address by STEP bytes
// modulo 2^ADDR_W. Assumes load_i and step_i are never high together.
module ldm_cursor #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 4,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [REG_W-1:0]  first_i,
    input  logic [REG_W-1:0]  last_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [REG_W-1:0]  reg_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_hit_o
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [REG_W-1:0]  reg_q;
    logic [REG_W-1:0]  end_q;
    logic [ADDR_W-1:0] addr_q;

    // Cursor update: latch on load, advance on step, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q  <= '0;
            end_q  <= '0;
            addr_q <= '0;
        end else if (load_i) begin
            reg_q  <= first_i;
            end_q  <= last_i;
            addr_q <= base_i;
        end else if (step_i) begin
            reg_q  <= reg_q + 1'b1;
            addr_q <= addr_q + STEP_V;
        end
    end

    // Outputs of the cursor and the end-of-range compare.
    always_comb begin
        reg_o      = reg_q;
        addr_o     = addr_q;
        last_hit_o = (reg_q == end_q);
    end

    // R3: a step moves to the next register number, wrapping at the top.
    p_reg_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (reg_q == $past(reg_q) + 1'b1));

    // R4: a step moves the byte address by one word, modulo the address space.
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (addr_q == $past(addr_q) + STEP_V));

    // R9: without load or step the cursor keeps its value.
    p_cursor_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> ($stable(reg_q) && $stable(addr_q) && $stable(end_q)));

endmodule

// File: rtl/ldm_pack.sv
// ldm_pack: reorders byte lanes into a big-endian word.
// Lane 0 (lowest address) lands in the most significant byte.
// Assumes DATA_W is a whole number of bytes.
module ldm_pack #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lanes_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int NBYTES = DATA_W / 8;

    // One lane swap per byte position.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign word_o[DATA_W-1-8*b -: 8] = lanes_i[8*b +: 8];
    end

endmodule

// File: rtl/ldm_sequencer.sv
// ldm_sequencer: top of the load-multiple sequencer.
// Loads registers first..last (wrapping) from consecutive words of
// byte-addressed storage, one outstanding read at a time, and writes
// each packed word through a registered register-file port.
// Assumes the storage side answers each request with exactly one valid.
module ldm_sequencer #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int REG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_W-1:0]  first_reg_i,
    input  logic [REG_W-1:0]  last_reg_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              rf_we_o,
    output logic [REG_W-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);

    localparam int STEP = DATA_W / 8;

    logic              load;
    logic              take;
    logic              step;
    logic              last_hit;
    logic [REG_W-1:0]  cur_reg;
    logic [DATA_W-1:0] packed_word;
    logic              we_q;
    logic [REG_W-1:0]  waddr_q;
    logic [DATA_W-1:0] wdata_q;

    ldm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .valid_i    (mem_valid_i),
        .last_hit_i (last_hit),
        .load_o     (load),
        .req_o      (mem_req_o),
        .take_o     (take),
        .step_o     (step),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    ldm_cursor #(
        .ADDR_W (ADDR_W),
        .REG_W  (REG_W),
        .STEP   (STEP)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .first_i    (first_reg_i),
        .last_i     (last_reg_i),
        .base_i     (base_addr_i),
        .reg_o      (cur_reg),
        .addr_o     (mem_addr_o),
        .last_hit_o (last_hit)
    );

    ldm_pack #(
        .DATA_W (DATA_W)
    ) u_pack (
        .lanes_i (mem_rdata_i),
        .word_o  (packed_word)
    );

    // Registered register-file write port, loaded when a word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= take;
            if (take) begin
                waddr_q <= cur_reg;
                wdata_q <= packed_word;
            end
        end
    end

    // Drive the write-port outputs.
    always_comb begin
        rf_we_o    = we_q;
        rf_waddr_o = waddr_q;
        rf_wdata_o = wdata_q;
    end

    // R6: every write follows a valid word on the previous cycle.
    p_write_from_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(mem_valid_i));

    // R2: an operation opens with a request at the supplied base address.
    p_first_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (mem_req_o && (mem_addr_o == $past(base_addr_i))));

    // R8: done is preceded by the final write.
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rf_we_o));

    // R5: no request while a write for a tail is pending or while idle.
    p_req_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (busy_o && !done_o));

endmodule

// File: tb/ldm_sequencer_tb.sv
// Bench for ldm_sequencer: a queue-based reference model compared on every clock.
module ldm_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  first;
    logic [3:0]  last;
    logic [23:0] base;
    logic        valid;
    logic [31:0] rdata;
    logic        busy_o, done_o, mem_req_o, rf_we_o;
    logic [23:0] mem_addr_o;
    logic [3:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;

    always #4 clk = ~clk;   // 125 MHz

    ldm_sequencer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .first_reg_i (first),
        .last_reg_i  (last),
        .base_addr_i (base),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_valid_i (valid),
        .mem_rdata_i (rdata),
        .rf_we_o     (rf_we_o),
        .rf_waddr_o  (rf_waddr_o),
        .rf_wdata_o  (rf_wdata_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model: expected outputs of the current cycle plus pending work.
    int unsigned q_addr[$];
    int          q_reg[$];
    int          op_len = 0;
    bit mb = 0, mq = 0, mw = 0, mt = 0, md = 0, ign = 0;
    int lat_cfg = 1;
    bit spur_cfg = 0;
    int cnt = 0;
    int unsigned paddr = 0;

    function automatic logic [7:0] mem_byte(int unsigned a);
        int unsigned x = a & 32'h00FF_FFFF;
        return 8'((x * 7) ^ ((x >> 8) * 13) ^ ((x >> 16) * 5) ^ 32'h5A);
    endfunction

    function automatic logic [31:0] exp_word(int unsigned a);
        return {mem_byte(a), mem_byte(a + 1), mem_byte(a + 2), mem_byte(a + 3)};
    endfunction

    function automatic logic [31:0] lanes(int unsigned a);
        return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: predict, wait for the negedge, compare, then drive the storage side.
    task automatic tick();
        bit nb = mb, nq = 0, nw = 0, nt = 0, nd = 0, nwe = 0;
        int nr = 0;
        logic [31:0] nwd = '0;
        string rtag;
        if (!mb) begin
            if (start && rst_n) begin
                int n = ((int'(last) - int'(first)) & 15) + 1;
                q_reg.delete();
                q_addr.delete();
                for (int i = 0; i < n; i++) begin
                    q_reg.push_back((int'(first) + i) & 15);
                    q_addr.push_back((int'(base) + 4 * i) & 32'h00FF_FFFF);
                end
                op_len = n;
                nb = 1; nq = 1; ign = 0;
            end
        end else begin
            if (start) ign = 1;
            if (mq) nw = 1;
            else if (mw) begin
                if (valid) begin
                    nwe = 1;
                    nr = q_reg.pop_front();
                    nwd = exp_word(q_addr.pop_front());
                    if (q_reg.size() == 0) nt = 1; else nq = 1;
                end else nw = 1;
            end
            else if (mt) nd = 1;
            else if (md) nb = 0;
        end
        @(negedge clk);
        chk("R1", "busy", busy_o, nb);
        rtag = ign ? "R9" : "R5";
        chk(rtag, "mem_req", mem_req_o, nq);
        if (nq) begin
            rtag = (q_reg.size() == op_len) ? "R2" : "R4";
            chk(rtag, "mem_addr", mem_addr_o, q_addr[0]);
        end
        chk("R6", "rf_we", rf_we_o, nwe);
        if (nwe) begin
            rtag = (q_reg.size() == op_len - 1) ? "R2" : "R3";
            chk(rtag, "rf_waddr", rf_waddr_o, nr);
            chk("R7", "rf_wdata", rf_wdata_o, nwd);
        end
        chk("R8", "done", done_o, nd);
        mb = nb; mq = nq; mw = nw; mt = nt; md = nd;
        // storage responder
        valid = 0;
        rdata = 32'hA5C3_0F96;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                valid = 1;
                rdata = lanes(paddr);
            end
        end
        if (nq) begin
            paddr = q_addr[0];
            cnt = lat_cfg;
            if (spur_cfg) valid = 1;   // R6: valid during the request cycle is ignored
        end
    endtask

    task automatic run_op(int f, int l, int unsigned b, int lat, bit spur,
                          int mid_at, bit start_on_done);
        int n = 0;
        lat_cfg = lat; spur_cfg = spur;
        first = 4'(f); last = 4'(l); base = 24'(b);
        start = 1;
        tick();
        start = 0;
        while (mb && n < 2000) begin
            if (n == mid_at) begin
                start = 1; first = ~first; base = ~base;   // R9: dropped
            end else if (start_on_done && md) begin
                start = 1;                                 // R9: dropped on done cycle
            end else start = 0;
            tick();
            n++;
        end
        start = 0;
        repeat (4) tick();
    endtask

    initial begin
        rst_n = 0; start = 0; first = 0; last = 0; base = 0; valid = 0; rdata = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "busy", busy_o, 0);
        chk("R10", "done", done_o, 0);
        chk("R10", "mem_req", mem_req_o, 0);
        chk("R10", "rf_we", rf_we_o, 0);
        rst_n = 1;
        repeat (2) tick();
        // R6: valid while idle changes nothing
        valid = 1; tick(); valid = 0; tick();
        run_op(4, 7, 32'h000100, 1, 0, -1, 0);        // R2 R3 R4 R7
        run_op(9, 9, 32'hABCDE0, 2, 0, -1, 0);        // R3 single register
        run_op(14, 1, 32'h002000, 3, 1, -1, 0);       // R3 wrap, R6 spurious valid
        run_op(0, 3, 32'hFFFFF8, 1, 0, -1, 0);        // R4 address wrap
        run_op(5, 4, 32'h012345, 2, 1, 5, 0);         // R3 sixteen registers, R9 mid start
        run_op(2, 6, 32'h7FFFFC, 1, 0, 3, 1);         // R8 done, R9 start on done
        run_op(15, 0, 32'h000040, 4, 0, -1, 1);       // R3 wrap of two registers
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule